// File: doc/BRIEF.md
# CAN Controller Clock-Stop Handshake

This block runs the power-down handshake between a CAN protocol engine and the clock manager that gates its clocks. A stop can be started by a hardware request pin or by a software stop bit. The block waits for every queued transmission to finish. After that it waits for the bus to go idle. It then forces the engine's initialization bit high, which freezes CAN traffic, and raises a registered acknowledge that tells the clock manager the clocks may be gated.

When the request goes away, the acknowledge falls and the block returns to normal operation. By default the initialization bit stays set, so software must clear it before traffic resumes. An optional auto-restart clears the bit by itself when the hardware request is released. Two enable bits must both be set for this, and no suspend request may be active. The hardware request passes through a parameterised synchronizer of `HW_SYNC_STAGES` flops, written S below. Every register uses a synchronous active-high reset.

Top module: `ccs_clock_stop`

## Requirements
- R1: While `rst` is high and after it is released, `stop_ack_o` and `stat_ack_o` are 0, `stat_req_o` is 0 and `init_o` equals `RESET_INIT` (default 1).
- R2: The effective request is the software stop bit OR'ed with the synchronized hardware request. `stat_req_o` shows this value, so it reads 1 S cycles after `hw_stop_req_i` rises, even if software has written the stop bit to 0.
- R3: While `tx_pending_i` is 1, the block does not move on to the bus-idle wait, even if `bus_idle_i` is already 1. With D extra cycles of pending transmit and I extra cycles of busy bus, the acknowledge rises L+4+D+I clock edges after the request is applied. L is 1 for a software write and S for the hardware pin.
- R4: `init_o` becomes 1 on the clock edge that ends the bus-idle wait, one edge before the acknowledge rises.
- R5: `stop_ack_o` and `stat_ack_o` are both 1 from then on, for as long as the request stays active.
- R6: A software write to the initialization bit takes effect on the next edge while the block is running. From the edge that forces the bit until the block is back in its running state, such writes are ignored.
- R7: Once the effective request reads 0, the acknowledge falls on the next clock edge. The block returns to its running state one edge after that.
- R8: In default mode `init_o` stays 1 after the stop ends. A later software write of 0 clears it.
- R9: If the stop was caused by the hardware pin, and both `auto_wake_en_i` and `wake_req_en_i` are 1 with `suspend_i` at 0, `init_o` clears by itself one edge after the acknowledge falls.
- R10: When `suspend_i` is 1, or either wake enable is 0, the automatic clear does not happen and `init_o` stays 1.
- R11: If the request is withdrawn before the acknowledge has risen, the block goes back to running without ever raising the acknowledge, and `init_o` keeps its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stop_req_i | input | 1 | Asynchronous hardware clock-stop request |
| wr_stop_en_i | input | 1 | Write strobe for the software stop bit |
| wr_stop_val_i | input | 1 | Value written to the software stop bit |
| wr_init_en_i | input | 1 | Write strobe for the initialization bit |
| wr_init_val_i | input | 1 | Value written to the initialization bit |
| tx_pending_i | input | 1 | Engine still has transmit requests outstanding |
| bus_idle_i | input | 1 | Engine reports an idle CAN bus |
| suspend_i | input | 1 | Suspend request; blocks automatic restart |
| auto_wake_en_i | input | 1 | Auto-restart enable |
| wake_req_en_i | input | 1 | Wake-request enable, needed with auto-restart |
| stop_ack_o | output | 1 | Registered acknowledge to the clock manager |
| init_o | output | 1 | Initialization bit driving the protocol engine |
| stat_req_o | output | 1 | Readable stop-request status |
| stat_ack_o | output | 1 | Readable acknowledge status |

## Verification
The hardest case to reach from the ports is the ordering between the transmit drain and the bus-idle wait. It can only be seen when the bus is already idle while transmissions are still pending, and the acknowledge must arrive only after both. The bench sweeps the drain length and the idle delay over a small grid, for both request sources and all eight combinations of the wake and suspend inputs. For each run it computes the exact edge at which the acknowledge must rise and checks every cycle around it. Withdrawing the request before the acknowledge is reached by holding either the drain or the busy bus until the request is removed.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DRAIN = 3'd1,
    ST_IDLE  = 3'd2,
    ST_STOP  = 3'd3,
    ST_EXIT  = 3'd4
  } ccs_state_e;
endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= '0;
        end else begin
          sr[0] <= d_i;
          for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign q_o = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ccs_req_merge.sv
module ccs_req_merge #(
  parameter int HW_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_stop_req_i,
  input  logic wr_stop_en_i,
  input  logic wr_stop_val_i,
  output logic hw_req_o,
  output logic req_o
);
  logic sw_stop_q;
  logic hw_sync;

  ccs_sync #(.STAGES(HW_SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (hw_stop_req_i),
    .q_o (hw_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) sw_stop_q <= 1'b0;
    else if (wr_stop_en_i) sw_stop_q <= wr_stop_val_i;
  end

  assign hw_req_o = hw_sync;
  assign req_o    = sw_stop_q | hw_sync;

  // R2: a software write of 1 is visible as a request on the next edge
  a_r2_sw_write_req: assert property (@(posedge clk) disable iff (rst)
    (wr_stop_en_i && wr_stop_val_i) |=> req_o);
endmodule

// File: rtl/ccs_fsm.sv
module ccs_fsm
  import ccs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic hw_req_i,
  input  logic tx_pending_i,
  input  logic bus_idle_i,
  input  logic suspend_i,
  input  logic auto_wake_en_i,
  input  logic wake_req_en_i,
  output logic ack_o,
  output logic force_init_o,
  output logic auto_clr_o,
  output logic wr_block_o
);
  ccs_state_e state_q, state_d;
  logic ack_q;
  logic hw_seen_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (req_i) state_d = ST_DRAIN;
      ST_DRAIN: if (!req_i) state_d = ST_RUN;
                else if (!tx_pending_i) state_d = ST_IDLE;
      ST_IDLE:  if (!req_i) state_d = ST_RUN;
                else if (bus_idle_i) state_d = ST_STOP;
      ST_STOP:  if (!req_i) state_d = ST_EXIT;
      ST_EXIT:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      ack_q     <= 1'b0;
      hw_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == ST_STOP) && req_i;
      if (state_q == ST_RUN) hw_seen_q <= 1'b0;
      else if (state_q == ST_STOP && hw_req_i) hw_seen_q <= 1'b1;
    end
  end

  assign ack_o        = ack_q;
  assign force_init_o = (state_q == ST_IDLE) && req_i && bus_idle_i;
  assign auto_clr_o   = (state_q == ST_EXIT) && !req_i && hw_seen_q &&
                        auto_wake_en_i && wake_req_en_i && !suspend_i;
  assign wr_block_o   = (state_q == ST_STOP) || (state_q == ST_EXIT);

  // R3: the bus-idle wait is entered only after the drain saw no pending transmit
  a_r3_drain_first: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && $past(state_q) == ST_DRAIN) |-> $past(!tx_pending_i));

  // R4: the acknowledge rises only after a cycle spent in the stopped state
  a_r4_ack_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(state_q) == ST_STOP);

  // R7: a withdrawn request drops the acknowledge on the next edge
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !req_i) |=> !ack_q);

  // R11: no acknowledge while waiting in the drain or idle stages
  a_r11_no_early_ack: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN || state_q == ST_IDLE) |-> !ack_q);
endmodule

// File: rtl/ccs_init_reg.sv
module ccs_init_reg #(
  parameter bit RESET_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic force_i,
  input  logic auto_clr_i,
  input  logic wr_block_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic init_o
);
  logic init_q;

  always_ff @(posedge clk) begin
    if (rst) init_q <= RESET_INIT;
    else if (force_i) init_q <= 1'b1;
    else if (auto_clr_i) init_q <= 1'b0;
    else if (wr_en_i && !wr_block_i) init_q <= wr_val_i;
  end

  assign init_o = init_q;

  // R6: a blocked write leaves the bit unchanged
  a_r6_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (wr_block_i && wr_en_i && !auto_clr_i && !force_i) |=> $stable(init_q));

  // R4: a forced entry always leaves the bit set
  a_r4_forced_set: assert property (@(posedge clk) disable iff (rst)
    force_i |=> init_q);
endmodule

// File: rtl/ccs_clock_stop.sv
module ccs_clock_stop #(
  parameter int HW_SYNC_STAGES = 2,
  parameter bit RESET_INIT     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_stop_req_i,
  input  logic wr_stop_en_i,
  input  logic wr_stop_val_i,
  input  logic wr_init_en_i,
  input  logic wr_init_val_i,
  input  logic tx_pending_i,
  input  logic bus_idle_i,
  input  logic suspend_i,
  input  logic auto_wake_en_i,
  input  logic wake_req_en_i,
  output logic stop_ack_o,
  output logic init_o,
  output logic stat_req_o,
  output logic stat_ack_o
);
  logic req, hw_req, ack, force_init, auto_clr, wr_block;

  ccs_req_merge #(.HW_SYNC_STAGES(HW_SYNC_STAGES)) u_req (
    .clk           (clk),
    .rst           (rst),
    .hw_stop_req_i (hw_stop_req_i),
    .wr_stop_en_i  (wr_stop_en_i),
    .wr_stop_val_i (wr_stop_val_i),
    .hw_req_o      (hw_req),
    .req_o         (req)
  );

  ccs_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .req_i          (req),
    .hw_req_i       (hw_req),
    .tx_pending_i   (tx_pending_i),
    .bus_idle_i     (bus_idle_i),
    .suspend_i      (suspend_i),
    .auto_wake_en_i (auto_wake_en_i),
    .wake_req_en_i  (wake_req_en_i),
    .ack_o          (ack),
    .force_init_o   (force_init),
    .auto_clr_o     (auto_clr),
    .wr_block_o     (wr_block)
  );

  ccs_init_reg #(.RESET_INIT(RESET_INIT)) u_init (
    .clk        (clk),
    .rst        (rst),
    .force_i    (force_init),
    .auto_clr_i (auto_clr),
    .wr_block_i (wr_block),
    .wr_en_i    (wr_init_en_i),
    .wr_val_i   (wr_init_val_i),
    .init_o     (init_o)
  );

  assign stop_ack_o = ack;
  assign stat_ack_o = ack;
  assign stat_req_o = req;

  // R5: the acknowledge is never given without the initialization bit set
  a_r5_ack_needs_init: assert property (@(posedge clk) disable iff (rst)
    stop_ack_o |-> init_o);

  // R10: with suspend active the bit never falls while no write is made
  a_r10_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(suspend_i) && !$past(wr_init_en_i) && $past(init_o)) |-> init_o);
endmodule

// File: tb/ccs_clock_stop_bench.sv
module ccs_clock_stop_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst;
  logic hw_stop_req, wr_stop_en, wr_stop_val, wr_init_en, wr_init_val;
  logic tx_pending, bus_idle, suspend, auto_wake_en, wake_req_en;
  logic stop_ack, init, stat_req, stat_ack;

  int n_checks = 0;
  int n_errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccs_clock_stop #(.HW_SYNC_STAGES(SYNC), .RESET_INIT(1'b1)) u_ccs_clock_stop (
    .clk            (clk),
    .rst            (rst),
    .hw_stop_req_i  (hw_stop_req),
    .wr_stop_en_i   (wr_stop_en),
    .wr_stop_val_i  (wr_stop_val),
    .wr_init_en_i   (wr_init_en),
    .wr_init_val_i  (wr_init_val),
    .tx_pending_i   (tx_pending),
    .bus_idle_i     (bus_idle),
    .suspend_i      (suspend),
    .auto_wake_en_i (auto_wake_en),
    .wake_req_en_i  (wake_req_en),
    .stop_ack_o     (stop_ack),
    .init_o         (init),
    .stat_req_o     (stat_req),
    .stat_ack_o     (stat_ack)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_init(input logic v);
    wr_init_en = 1'b1; wr_init_val = v;
    tick();
    wr_init_en = 1'b0;
  endtask

  // one full stop/exit cycle; src_hw selects the request source
  task automatic run_cycle(input bit src_hw, input int d, input int idl,
                           input bit aw, input bit we, input bit sus);
    int lat, t;
    logic exp_init;
    write_init(1'b0);
    chk("R6", "init write while running", init, 1'b0);
    auto_wake_en = aw; wake_req_en = we; suspend = sus;
    lat = src_hw ? SYNC : 1;
    t   = lat + 4 + d + idl;
    if (src_hw) hw_stop_req = 1'b1;
    else begin wr_stop_en = 1'b1; wr_stop_val = 1'b1; end
    tx_pending = (1 <= lat + 1 + d);
    bus_idle   = 1'b1;
    if (idl > 0 || d > 0) bus_idle = (1 > lat + 2 + d + idl) || (d > 0);
    for (int e = 1; e <= t + 1; e++) begin
      tick();
      wr_stop_en = 1'b0;
      chk("R3", "ack timing", stop_ack, (e >= t));
      chk("R5", "status ack", stat_ack, (e >= t));
      if (e == t - 2) chk("R4", "init before force", init, 1'b0);
      if (e == t - 1) chk("R4", "init forced", init, 1'b1);
      tx_pending = (e + 1 <= lat + 1 + d);
      // bus idle held high during the drain to prove it is ignored there,
      // low for idl cycles after it, then high
      bus_idle = (e + 1 <= lat + 1 + d) ? 1'b1 : (e + 1 > lat + 2 + d + idl);
    end
    chk("R2", "request readback", stat_req, 1'b1);
    if (src_hw) begin
      wr_stop_en = 1'b1; wr_stop_val = 1'b0;
      tick();
      wr_stop_en = 1'b0;
      chk("R2", "readback with hw and sw bit 0", stat_req, 1'b1);
    end
    write_init(1'b0);
    chk("R6", "blocked init write", init, 1'b1);
    chk("R5", "ack held", stop_ack, 1'b1);
    if (src_hw) hw_stop_req = 1'b0;
    else begin wr_stop_en = 1'b1; wr_stop_val = 1'b0; end
    exp_init = !(src_hw && aw && we && !sus);
    for (int e = 1; e <= lat + 2; e++) begin
      tick();
      wr_stop_en = 1'b0;
      chk("R7", "ack release", stop_ack, (e <= lat));
      if (e == lat + 1) chk("R8", "init still set at ack drop", init, 1'b1);
      if (e == lat + 2) begin
        if (exp_init) chk(sus ? "R10" : "R8", "init after exit", init, exp_init);
        else          chk("R9", "auto clear after exit", init, exp_init);
      end
    end
    if (init) begin
      write_init(1'b0);
      chk("R8", "software clear after exit", init, 1'b0);
    end
    bus_idle = 1'b0; tx_pending = 1'b0;
  endtask

  // request withdrawn before acknowledge; hold_tx keeps the drain stage busy
  task automatic run_abort(input bit hold_tx, input logic pre_init);
    write_init(pre_init);
    tx_pending = hold_tx; bus_idle = 1'b0;
    wr_stop_en = 1'b1; wr_stop_val = 1'b1;
    tick();
    wr_stop_en = 1'b0;
    for (int e = 0; e < 4; e++) begin
      tick();
      chk("R11", "no ack while waiting", stop_ack, 1'b0);
    end
    wr_stop_en = 1'b1; wr_stop_val = 1'b0;
    tick();
    wr_stop_en = 1'b0;
    tx_pending = 1'b0; bus_idle = 1'b1;
    for (int e = 0; e < 4; e++) begin
      tick();
      chk("R11", "no ack after abort", stop_ack, 1'b0);
      chk("R11", "init kept after abort", init, pre_init);
    end
    bus_idle = 1'b0;
    write_init(~pre_init);
    chk("R11", "running again after abort", init, ~pre_init);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    rst = 1'b1;
    hw_stop_req = 1'b0; wr_stop_en = 1'b0; wr_stop_val = 1'b0;
    wr_init_en = 1'b0; wr_init_val = 1'b0;
    tx_pending = 1'b0; bus_idle = 1'b0; suspend = 1'b0;
    auto_wake_en = 1'b0; wake_req_en = 1'b0;
    @(negedge clk);
    tick(); tick();
    chk("R1", "ack in reset", stop_ack, 1'b0);
    chk("R1", "init in reset", init, 1'b1);
    rst = 1'b0;
    tick();
    chk("R1", "ack after reset", stop_ack, 1'b0);
    chk("R1", "status ack after reset", stat_ack, 1'b0);
    chk("R1", "status req after reset", stat_req, 1'b0);
    chk("R1", "init after reset", init, 1'b1);

    for (int src = 0; src < 2; src++)
      for (int d = 0; d < 3; d++)
        for (int idl = 0; idl < 3; idl++)
          for (int m = 0; m < 8; m++)
            run_cycle(src[0], d, idl, m[0], m[1], m[2]);

    run_abort(1'b1, 1'b0);
    run_abort(1'b1, 1'b1);
    run_abort(1'b0, 1'b0);
    run_abort(1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule